// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It supports word load and store, register add, subtract, and, or and signed set-less-than, branch-if-equal and an absolute jump. Each instruction is fetched from a local instruction array at the current program counter and decoded. Its operands are read from a 32-entry register file. The result is committed at the next rising edge, together with the new program counter.

Control has two levels. An opcode decoder produces the datapath selects and a 2-bit ALU class. A second decoder combines that class with the low function bits of the instruction to pick the ALU operation. The instruction array and the data array both have combinational reads. A simple preload port fills either array before the core is released from reset. This port has no back-pressure: a word presented with its strobe high is accepted at that edge.

For checking, the core exposes the program counter and the register-file write port. This port carries the enable, the destination index and the write value of the instruction now executing.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0. While `rst` is high, `rf_we_o` is 0 and no store takes place.
- R2: An instruction that neither jumps nor takes a branch moves the program counter to PC+4.
- R3: Opcode 0 with function code 0x20, 0x22, 0x24, 0x25 or 0x2A performs add, subtract, and, or or signed set-less-than on registers rs (bits 25:21) and rt (bits 20:16). The result is written to rd (bits 15:11).
- R4: Opcode 35 loads the data word at rs plus the sign-extended offset (bits 15:0) into register rt. The offset may be negative.
- R5: Opcode 43 stores register rt to the data word at rs plus the sign-extended offset. It writes no register.
- R6: Opcode 4 compares rs with rt. When they are equal, the next PC is PC+4 plus the sign-extended offset times 4. Otherwise the next PC is PC+4. No register is written.
- R7: Opcode 2 sets the PC to the upper 4 bits of PC+4, followed by bits 25:0 of the instruction, followed by two zero bits. No register is written.
- R8: Register 0 always reads as 0. A write aimed at it is reported on the write port but has no effect.
- R9: An instruction whose source register is also its destination reads the value held before that instruction commits.
- R10: With `ld_we` high at a rising edge, `ld_data` is written to word `ld_addr` of the instruction array (`ld_imem`=1) or of the data array (`ld_imem`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_we | input | 1 | Preload write strobe |
| ld_imem | input | 1 | Preload target: 1 selects the instruction array, 0 selects the data array |
| ld_addr | input | MEM_AW | Preload word index |
| ld_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write enable of the current instruction |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Value to be written to the register |

## Verification
In one cycle, a register can be read as a source and also be the target of that instruction's write. The test program provokes this with an add whose sources and destination are the same register. The expected value is computed from the old contents, so the read must return the value held before the commit. A second overlap is a write to register 0 followed by a read of it. Here, the read must still return zero. Every cycle is judged on the exposed program counter and write port against a queue of expected results.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JUMP  = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;

  // ALU class from the opcode decoder
  localparam logic [1:0] CLS_MEM    = 2'b00;
  localparam logic [1:0] CLS_BRANCH = 2'b01;
  localparam logic [1:0] CLS_FUNCT  = 2'b10;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_sel_e;

  typedef struct packed {
    logic       dst_is_rd;
    logic       b_is_imm;
    logic       wb_from_mem;
    logic       reg_write;
    logic       mem_read;
    logic       mem_write;
    logic       branch;
    logic       jump;
    logic [1:0] alu_cls;
  } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.alu_cls   = CLS_FUNCT;
      end
      OP_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_write   = 1'b1;
        ctrl.mem_read    = 1'b1;
        ctrl.alu_cls     = CLS_MEM;
      end
      OP_STORE: begin
        ctrl.b_is_imm  = 1'b1;
        ctrl.mem_write = 1'b1;
        ctrl.alu_cls   = CLS_MEM;
      end
      OP_BEQ: begin
        ctrl.branch  = 1'b1;
        ctrl.alu_cls = CLS_BRANCH;
      end
      OP_JUMP: begin
        ctrl.jump = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
  import sc_pkg::*;
(
  input  logic [1:0] alu_cls,
  input  logic [5:0] funct,
  output alu_sel_e   sel
);
  logic unused_funct_hi;
  assign unused_funct_hi = ^funct[5:4];

  always_comb begin
    if (alu_cls == CLS_MEM) begin
      sel = ALU_ADD;
    end else if (alu_cls[0]) begin
      sel = ALU_SUB;
    end else begin
      unique case (funct[3:0])
        4'b0000: sel = ALU_ADD;
        4'b0010: sel = ALU_SUB;
        4'b0100: sel = ALU_AND;
        4'b0101: sel = ALU_OR;
        4'b1010: sel = ALU_SLT;
        default: sel = ALU_ADD;
      endcase
    end
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_sel_e     sel,
  output logic [W-1:0] result,
  output logic         zero
);
  always_comb begin
    unique case (sel)
      ALU_AND: result = a & b;
      ALU_OR:  result = a | b;
      ALU_SUB: result = a - b;
      ALU_SLT: result = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: result = a + b;
    endcase
  end
  assign zero = (result == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W     = 32,
  parameter int NREGS = 32,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [W-1:0]   wdata,
  input  logic [RAW-1:0] raddr_a,
  input  logic [RAW-1:0] raddr_b,
  output logic [W-1:0]   rdata_a,
  output logic [W-1:0]   rdata_b
);
  logic [W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  // index 0 is hard-wired to zero (R8)
  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

  // R3: an enabled write to a nonzero index lands at the next edge
  p_rf_write_lands_r3: assert property (@(posedge clk)
    (we && (waddr != '0)) |=> (regs[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int W  = 32,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];

  // R5 / R10: a write strobe stores the word at the addressed slot
  p_mem_store_r5: assert property (@(posedge clk)
    we |=> (words[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic              ld_imem,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [31:0]       ld_data,
  output logic [31:0]       pc_o,
  output logic              rf_we_o,
  output logic [4:0]        rf_waddr_o,
  output logic [31:0]       rf_wdata_o
);
  localparam int XW = 32;
  localparam int WA_HI = MEM_AW + 1;

  logic [XW-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
  logic [XW-1:0] instr, imm_ext, rd_a, rd_b, alu_b, alu_res, dmem_rd;
  logic [XW-1:0] wb_data;
  logic [4:0]    wb_addr;
  logic          alu_zero, taken, rf_we;
  logic          dmem_we;
  logic [MEM_AW-1:0] dmem_waddr;
  logic [XW-1:0]     dmem_wdata;
  ctrl_t         ctrl;
  alu_sel_e      alu_sel;

  // fetch
  sc_mem #(.W(XW), .AW(MEM_AW)) u_imem (
    .clk(clk), .we(ld_we & ld_imem), .waddr(ld_addr), .wdata(ld_data),
    .raddr(pc_q[WA_HI:2]), .rdata(instr)
  );

  // decode
  sc_main_dec u_dec (.opcode(instr[31:26]), .ctrl(ctrl));
  sc_alu_ctrl u_actl (.alu_cls(ctrl.alu_cls), .funct(instr[5:0]), .sel(alu_sel));

  sc_regfile #(.W(XW), .NREGS(32)) u_rf (
    .clk(clk), .we(rf_we), .waddr(wb_addr), .wdata(wb_data),
    .raddr_a(instr[25:21]), .raddr_b(instr[20:16]),
    .rdata_a(rd_a), .rdata_b(rd_b)
  );

  assign imm_ext = {{16{instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.b_is_imm ? imm_ext : rd_b;

  // execute
  sc_alu #(.W(XW)) u_alu (
    .a(rd_a), .b(alu_b), .sel(alu_sel), .result(alu_res), .zero(alu_zero)
  );

  // data memory, preload port has priority
  always_comb begin
    if (ld_we && !ld_imem) begin
      dmem_we    = 1'b1;
      dmem_waddr = ld_addr;
      dmem_wdata = ld_data;
    end else begin
      dmem_we    = ctrl.mem_write & ~rst;
      dmem_waddr = alu_res[WA_HI:2];
      dmem_wdata = rd_b;
    end
  end

  sc_mem #(.W(XW), .AW(MEM_AW)) u_dmem (
    .clk(clk), .we(dmem_we), .waddr(dmem_waddr), .wdata(dmem_wdata),
    .raddr(alu_res[WA_HI:2]), .rdata(dmem_rd)
  );

  // write back
  assign wb_addr = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
  assign wb_data = ctrl.wb_from_mem ? dmem_rd : alu_res;
  assign rf_we   = ctrl.reg_write & ~rst;

  // next PC
  assign pc_plus4   = pc_q + 32'd4;
  assign br_target  = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign taken      = ctrl.branch & alu_zero;

  always_comb begin
    if (ctrl.jump)  pc_next = jmp_target;
    else if (taken) pc_next = br_target;
    else            pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = rf_we;
  assign rf_waddr_o = wb_addr;
  assign rf_wdata_o = wb_data;

  logic unused_bits;
  assign unused_bits = ^{pc_q[1:0], pc_q[XW-1:WA_HI+1], alu_res[1:0],
                         alu_res[XW-1:WA_HI+1], instr[10:6], ctrl.mem_read};

  // R1: reset forces the PC to zero
  p_reset_pc_r1: assert property (@(posedge clk)
    rst |=> (pc_q == '0));

  // R2: fall-through advances by one word
  p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !taken) |=> (pc_q == $past(pc_q) + 32'd4));

  // R6: a taken branch lands on its target
  p_branch_target_r6: assert property (@(posedge clk) disable iff (rst)
    taken |=> (pc_q == $past(br_target)));

  // R7: jump replaces the low 28 bits of the PC
  p_jump_low_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (pc_q[27:0] == {$past(instr[25:0]), 2'b00}));

  // R5: store, register write, branch and jump never combine
  p_ctrl_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.reg_write, ctrl.mem_write, ctrl.branch, ctrl.jump}));
endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
  localparam int MEM_AW = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ld_we = 1'b0;
  logic              ld_imem = 1'b0;
  logic [MEM_AW-1:0] ld_addr = '0;
  logic [31:0]       ld_data = '0;
  logic [31:0]       pc_o;
  logic              rf_we_o;
  logic [4:0]        rf_waddr_o;
  logic [31:0]       rf_wdata_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sc_core #(.MEM_AW(MEM_AW)) i_sc_core (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_imem(ld_imem),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o)
  );

  typedef struct {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    string       req;
  } exp_t;

  exp_t exp_q[$];

  function automatic logic [31:0] rt_op(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] it_op(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic expect_step(logic [31:0] pc, logic we, int wa, logic [31:0] wd, string req);
    exp_t e;
    e.pc = pc; e.we = we; e.wa = 5'(wa); e.wd = wd; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic load_word(logic imem, int addr, logic [31:0] data);
    @(negedge clk);
    ld_we = 1'b1; ld_imem = imem; ld_addr = MEM_AW'(addr); ld_data = data;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic check_now(logic [31:0] pc_e, logic we_e, string req);
    total++;
    if (pc_o !== pc_e || rf_we_o !== we_e) begin
      bad++;
      $display("FAIL %s pc=%h/%h we=%0d/%0d", req, pc_o, pc_e, rf_we_o, we_e);
    end
  endtask

  // monitor: one expected item per cycle while out of reset
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      total++;
      if (pc_o !== e.pc || rf_we_o !== e.we ||
          (e.we && (rf_waddr_o !== e.wa || rf_wdata_o !== e.wd))) begin
        bad++;
        $display("FAIL %s pc=%h/%h we=%0d/%0d wa=%0d/%0d wd=%h/%h", e.req,
                 pc_o, e.pc, rf_we_o, e.we, rf_waddr_o, e.wa, rf_wdata_o, e.wd);
      end
    end
  end

  // watchdog
  initial begin
    repeat (3000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10: preload both arrays through the load port
    load_word(1'b0, 0, 32'd5);
    load_word(1'b0, 1, 32'd7);
    load_word(1'b1, 0,  it_op(6'd35, 0, 1, 0));        // lw r1,0(r0)
    load_word(1'b1, 1,  it_op(6'd35, 0, 2, 4));        // lw r2,4(r0)
    load_word(1'b1, 2,  rt_op(1, 2, 3, 6'h20));        // add r3
    load_word(1'b1, 3,  rt_op(1, 2, 4, 6'h22));        // sub r4
    load_word(1'b1, 4,  rt_op(1, 2, 5, 6'h24));        // and r5
    load_word(1'b1, 5,  rt_op(1, 2, 6, 6'h25));        // or r6
    load_word(1'b1, 6,  rt_op(4, 1, 7, 6'h2A));        // slt r7 = (-2<5)
    load_word(1'b1, 7,  rt_op(1, 4, 8, 6'h2A));        // slt r8 = (5<-2)
    load_word(1'b1, 8,  it_op(6'd43, 0, 3, 8));        // sw r3,8(r0)
    load_word(1'b1, 9,  it_op(6'd35, 0, 9, 8));        // lw r9,8(r0)
    load_word(1'b1, 10, rt_op(1, 2, 0, 6'h20));        // add r0 (ignored)
    load_word(1'b1, 11, rt_op(0, 1, 10, 6'h20));       // add r10 = r0+r1
    load_word(1'b1, 12, it_op(6'd4, 1, 2, 5));         // beq not taken
    load_word(1'b1, 13, it_op(6'd4, 3, 9, 2));         // beq taken -> 64
    load_word(1'b1, 14, rt_op(1, 1, 11, 6'h20));       // skipped
    load_word(1'b1, 15, rt_op(1, 1, 11, 6'h20));       // skipped
    load_word(1'b1, 16, it_op(6'd35, 3, 12, -8));      // lw r12,-8(r3)
    load_word(1'b1, 17, {6'd2, 26'd20});               // j word 20
    load_word(1'b1, 18, rt_op(1, 1, 11, 6'h20));       // skipped
    load_word(1'b1, 19, rt_op(1, 1, 11, 6'h20));       // skipped
    load_word(1'b1, 20, rt_op(2, 2, 2, 6'h20));        // add r2=r2+r2
    load_word(1'b1, 21, it_op(6'd4, 0, 0, -1));        // beq self loop

    @(posedge clk); @(negedge clk);
    check_now(32'd0, 1'b0, "R1 reset state");

    expect_step(32'd0,  1, 1,  32'd5,        "R4 load");
    expect_step(32'd4,  1, 2,  32'd7,        "R4 load second word");
    expect_step(32'd8,  1, 3,  32'd12,       "R3 add");
    expect_step(32'd12, 1, 4,  32'hFFFFFFFE, "R3 sub");
    expect_step(32'd16, 1, 5,  32'd5,        "R3 and");
    expect_step(32'd20, 1, 6,  32'd7,        "R3 or");
    expect_step(32'd24, 1, 7,  32'd1,        "R3 slt true");
    expect_step(32'd28, 1, 8,  32'd0,        "R3 slt false");
    expect_step(32'd32, 0, 0,  32'd0,        "R5 store no write");
    expect_step(32'd36, 1, 9,  32'd12,       "R5 stored word read back");
    expect_step(32'd40, 1, 0,  32'd12,       "R8 write to r0 reported");
    expect_step(32'd44, 1, 10, 32'd5,        "R8 r0 still zero");
    expect_step(32'd48, 0, 0,  32'd0,        "R6 not taken");
    expect_step(32'd52, 0, 0,  32'd0,        "R2 R6 fall through");
    expect_step(32'd64, 1, 12, 32'd7,        "R6 taken R4 negative offset");
    expect_step(32'd68, 0, 0,  32'd0,        "R2 before jump");
    expect_step(32'd80, 1, 2,  32'd14,       "R7 jump R9 read old value");
    expect_step(32'd84, 0, 0,  32'd0,        "R2 into loop");
    expect_step(32'd84, 0, 0,  32'd0,        "R6 backward branch");
    expect_step(32'd84, 0, 0,  32'd0,        "R6 backward branch again");

    @(posedge clk); #1 rst = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);

    // second reset in the middle of a run
    @(posedge clk); #1 rst = 1'b1;
    @(negedge clk);
    check_now(32'd84, 1'b0, "R1 no write while reset held");
    @(negedge clk);
    check_now(32'd0, 1'b0, "R1 PC cleared by reset");
    expect_step(32'd0, 1, 1, 32'd5, "R1 restart from zero");
    @(posedge clk); #1 rst = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule